// File: doc/BRIEF.md
# MAC Address Provisioning Sequencer

This block drives a word-wide serial configuration EEPROM through a separate EEPROM master. On a start pulse it checks that the EEPROM carries the expected three-word signature. It then reads the stored 48-bit station address and shows it on an output. If the caller asked for it, the block also writes a new 48-bit address back into the same three words.

The block never toggles a serial pin itself. Each EEPROM access is a single request to the master: an opcode, a 6-bit word address and, for writes, a 16-bit data word. The request stays up until the master returns a one-cycle acknowledge, which carries the read data and an error flag.

Updating the address follows a fixed order. The device is write-enabled first. Each address word is then erased and rewritten in turn. The device is write-disabled at the end, even if a write failed along the way.

The result is reported with a one-cycle done pulse and a 2-bit status code.

Top module: `mac_prov_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `eer_req`, `done`, `busy` and `old_mac_valid` are 0, and `status` is 0.
- R2: The first three requests are reads of words 0, 1 and 2, in that order. Their data must be 0x8129, 0x10EC and 0x8168. At the first word that does not match, the block ends with status 1 (bad header) and issues no further request.
- R3: Address byte i (byte 0 is `old_mac[47:40]`, byte 5 is `old_mac[7:0]`) is stored in word 7+i/2. Even-numbered bytes sit in bits 7:0 and odd-numbered bytes in bits 15:8. After reads of words 7, 8 and 9, `old_mac` holds the assembled address and `old_mac_valid` is 1. Both are set before any erase or write request is issued.
- R4: With `update_en` at 0 when start is accepted, the run is exactly six reads (words 0, 1, 2, 7, 8, 9). It then ends with status 0.
- R5: With `update_en` at 1, the reads are followed by these requests: enable (op 3), then erase (op 2) and write (op 1) for word 7, then for word 8, then for word 9, then disable (op 4). Each write carries the packed new address word, using the layout of R3 with `new_mac`. A read is op 0.
- R6: An acknowledged erase or write with `eer_err` set does not stop the run. All remaining steps, including the disable, are still issued, and the run ends with status 2 (write failure).
- R7: While `eer_req` is high and not yet acknowledged, `eer_op`, `eer_addr` and `eer_wdata` hold steady. The cycle after an acknowledge, `eer_req` is low.
- R8: `done` is a one-cycle pulse. `busy` is high from the cycle after start is accepted until the cycle in which `done` is high, where it is already low.
- R9: A start pulse while `busy` is high is ignored. The current run's requests, result and written data are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| update_en | input | 1 | 1: read and rewrite the address; 0: read only |
| new_mac | input | 48 | Address to write; byte 0 in bits 47:40 |
| eer_req | output | 1 | Request to the EEPROM master |
| eer_op | output | 3 | 0 read, 1 write, 2 erase, 3 enable, 4 disable |
| eer_addr | output | 6 | Word address |
| eer_wdata | output | 16 | Write data |
| eer_ack | input | 1 | One-cycle completion from the master |
| eer_rdata | input | 16 | Read data, valid with `eer_ack` |
| eer_err | input | 1 | Error flag, valid with `eer_ack` |
| old_mac | output | 48 | Address read from the EEPROM |
| old_mac_valid | output | 1 | `old_mac` is complete for this run |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| status | output | 2 | 0 success, 1 bad header, 2 write failure |

## Verification
The bench corrupts each of the three header words in turn. A checker that tested only one word, or kept going after a mismatch, would issue extra reads or even write commands to an invalid part.

It injects a failed write on each of the three address words. A design that stopped early would leave the device write-enabled, which the bench's model EEPROM exposes. A design that lost the error would report success.

Random addresses catch swapped byte lanes in packing or unpacking. The bench also pokes start with different arguments in the middle of a run. A design that restarted or relatched its inputs would change the request log or the stored words.

// File: rtl/mps_pkg.sv
// Shared encodings for the MAC address provisioning sequencer.
// Assumes the EEPROM master decodes these opcodes as listed.
package mps_pkg;
    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_ERASE = 3'd2,
        OP_WREN  = 3'd3,
        OP_WRDIS = 3'd4
    } ee_op_t;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_BAD_HDR = 2'd1,
        RES_WR_FAIL = 2'd2
    } res_t;
endpackage

// File: rtl/mps_step_decode.sv
// Maps the sequencer step index onto one EEPROM request: opcode,
// word address and write data. The step list is header reads,
// address reads, enable, erase/write pairs, disable.
// Assumes step never exceeds the disable step.
module mps_step_decode
    import mps_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int WORD_W   = 16,
    parameter int N_HDR    = 3,
    parameter int N_MAC    = 3,
    parameter int MAC_BASE = 7,
    parameter int SW       = 4
) (
    input  logic [SW-1:0]           step,
    input  logic [N_MAC*WORD_W-1:0] new_words,
    output ee_op_t                  op,
    output logic [ADDR_W-1:0]       addr,
    output logic [WORD_W-1:0]       wdata
);
    localparam int S_WREN  = N_HDR + N_MAC;
    localparam int S_PAIR0 = S_WREN + 1;
    localparam int S_WRDIS = S_PAIR0 + 2 * N_MAC;

    int s_i;
    int pair_i;

    // Decode the step index into the request fields.
    always_comb begin
        op     = OP_READ;
        addr   = '0;
        wdata  = '0;
        s_i    = int'(step);
        pair_i = 0;
        if (s_i < N_HDR) begin
            addr = ADDR_W'(s_i);
        end else if (s_i < S_WREN) begin
            addr = ADDR_W'(MAC_BASE + s_i - N_HDR);
        end else if (s_i == S_WREN) begin
            op = OP_WREN;
        end else if (s_i < S_WRDIS) begin
            pair_i = s_i - S_PAIR0;
            op     = pair_i[0] ? OP_WRITE : OP_ERASE;
            addr   = ADDR_W'(MAC_BASE + pair_i / 2);
            wdata  = new_words[(pair_i / 2) * WORD_W +: WORD_W];
        end else begin
            op = OP_WRDIS;
        end
    end
endmodule

// File: rtl/mps_hdr_check.sv
// Compares one read word against the expected signature word chosen
// by the header index. Assumes idx < N_HDR when the result is used.
module mps_hdr_check #(
    parameter int WORD_W = 16,
    parameter int N_HDR  = 3,
    parameter int IDX_W  = 2,
    parameter logic [N_HDR*WORD_W-1:0] HDR_WORDS = 48'h8168_10EC_8129
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] word,
    output logic              match
);
    logic [WORD_W-1:0] expect_w;

    // Select the expected word and compare.
    always_comb begin
        expect_w = '0;
        for (int k = 0; k < N_HDR; k++) begin
            if (int'(idx) == k) expect_w = HDR_WORDS[k*WORD_W +: WORD_W];
        end
        match = (word == expect_w);
    end
endmodule

// File: rtl/mps_mac_reg.sv
// Holds the new address latched at start, packs it into EEPROM words,
// and assembles the old address from captured words. Byte i of an
// address sits at bits [MAC_W-1-8i -: 8]; inside a word the lower
// numbered byte takes the low lane. Assumes captures arrive in index order.
module mps_mac_reg #(
    parameter int MAC_W  = 48,
    parameter int WORD_W = 16,
    parameter int N_MAC  = 3,
    parameter int IDX_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic [MAC_W-1:0]        mac_in,
    input  logic                    cap,
    input  logic [IDX_W-1:0]        cap_idx,
    input  logic [WORD_W-1:0]       cap_word,
    output logic [N_MAC*WORD_W-1:0] new_words,
    output logic [MAC_W-1:0]        old_mac,
    output logic                    old_valid
);
    localparam int BPW = WORD_W / 8;

    logic [MAC_W-1:0] new_mac_q;

    // Latch the new address when a run starts.
    always_ff @(posedge clk) begin
        if (!rst_n)   new_mac_q <= '0;
        else if (clr) new_mac_q <= mac_in;
    end

    // Pack the latched address into per-word images.
    for (genvar k = 0; k < N_MAC; k++) begin : g_pack
        for (genvar b = 0; b < BPW; b++) begin : g_byte
            assign new_words[k*WORD_W + b*8 +: 8] =
                new_mac_q[MAC_W-1-8*(k*BPW+b) -: 8];
        end
    end

    // Unpack each captured word into the old address; flag after the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            old_mac   <= '0;
            old_valid <= 1'b0;
        end else if (clr) begin
            old_valid <= 1'b0;
        end else if (cap) begin
            for (int k = 0; k < N_MAC; k++) begin
                if (int'(cap_idx) == k) begin
                    for (int b = 0; b < BPW; b++) begin
                        old_mac[MAC_W-1-8*(k*BPW+b) -: 8] <= cap_word[b*8 +: 8];
                    end
                end
            end
            if (int'(cap_idx) == N_MAC - 1) old_valid <= 1'b1;
        end
    end

    // R3: once complete, the old address is frozen until the next run.
    a_r3_old_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        old_valid && !clr |=> old_valid && $stable(old_mac));
endmodule

// File: rtl/mac_prov_seq.sv
// Sequencer that validates an EEPROM signature, reads the stored MAC
// address and optionally rewrites it through a request/ack EEPROM
// master. Assumes the master acknowledges every request once, with a
// one-cycle eer_ack, and holds nothing across requests.
module mac_prov_seq
    import mps_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int WORD_W   = 16,
    parameter int MAC_W    = 48,
    parameter int N_HDR    = 3,
    parameter int MAC_BASE = 7,
    parameter logic [N_HDR*WORD_W-1:0] HDR_WORDS = 48'h8168_10EC_8129
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              update_en,
    input  logic [MAC_W-1:0]  new_mac,
    output logic              eer_req,
    output logic [2:0]        eer_op,
    output logic [ADDR_W-1:0] eer_addr,
    output logic [WORD_W-1:0] eer_wdata,
    input  logic              eer_ack,
    input  logic [WORD_W-1:0] eer_rdata,
    input  logic              eer_err,
    output logic [MAC_W-1:0]  old_mac,
    output logic              old_mac_valid,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status
);
    localparam int N_MAC   = MAC_W / WORD_W;
    localparam int S_WREN  = N_HDR + N_MAC;
    localparam int S_WRDIS = S_WREN + 1 + 2 * N_MAC;
    localparam int SW      = $clog2(S_WRDIS + 1);
    localparam int HIDX_W  = (N_HDR > 1) ? $clog2(N_HDR) : 1;
    localparam int MIDX_W  = (N_MAC > 1) ? $clog2(N_MAC) : 1;

    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_GAP} state_t;

    state_t  state;
    logic [SW-1:0] step;
    logic    upd_q;
    logic    err_q;
    res_t    res_q;
    ee_op_t  op_w;
    logic    hdr_match;
    logic    is_hdr, is_mac, is_wr;
    logic    start_ok, acked;
    logic [N_MAC*WORD_W-1:0] new_words;
    logic [SW-1:0] mac_step;

    mps_step_decode #(
        .ADDR_W(ADDR_W), .WORD_W(WORD_W), .N_HDR(N_HDR),
        .N_MAC(N_MAC), .MAC_BASE(MAC_BASE), .SW(SW)
    ) u_dec (
        .step(step), .new_words(new_words),
        .op(op_w), .addr(eer_addr), .wdata(eer_wdata)
    );

    mps_hdr_check #(
        .WORD_W(WORD_W), .N_HDR(N_HDR), .IDX_W(HIDX_W), .HDR_WORDS(HDR_WORDS)
    ) u_hdr (
        .idx(step[HIDX_W-1:0]), .word(eer_rdata), .match(hdr_match)
    );

    // Classify the current step.
    always_comb begin
        is_hdr   = int'(step) < N_HDR;
        is_mac   = !is_hdr && int'(step) < S_WREN;
        is_wr    = (op_w == OP_ERASE) || (op_w == OP_WRITE);
        start_ok = (state == ST_IDLE) && start;
        acked    = (state == ST_ISSUE) && eer_ack;
        mac_step = step - SW'(N_HDR);
    end

    mps_mac_reg #(
        .MAC_W(MAC_W), .WORD_W(WORD_W), .N_MAC(N_MAC), .IDX_W(MIDX_W)
    ) u_mac (
        .clk(clk), .rst_n(rst_n), .clr(start_ok), .mac_in(new_mac),
        .cap(acked && is_mac), .cap_idx(mac_step[MIDX_W-1:0]),
        .cap_word(eer_rdata), .new_words(new_words),
        .old_mac(old_mac), .old_valid(old_mac_valid)
    );

    // Step through the request list, end early on a bad header or a
    // read-only run, and gather erase/write errors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            step  <= '0;
            upd_q <= 1'b0;
            err_q <= 1'b0;
            res_q <= RES_OK;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_ISSUE;
                        step  <= '0;
                        upd_q <= update_en;
                        err_q <= 1'b0;
                    end
                end
                ST_ISSUE: begin
                    if (eer_ack) begin
                        err_q <= err_q | (eer_err && is_wr);
                        if (is_hdr && !hdr_match) begin
                            res_q <= RES_BAD_HDR;
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else if (int'(step) == S_WREN - 1 && !upd_q) begin
                            res_q <= RES_OK;
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else if (int'(step) == S_WRDIS) begin
                            res_q <= err_q ? RES_WR_FAIL : RES_OK;
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            step  <= step + 1'b1;
                            state <= ST_GAP;
                        end
                    end
                end
                default: state <= ST_ISSUE;
            endcase
        end
    end

    // Drive the master and status outputs.
    always_comb begin
        eer_req = (state == ST_ISSUE);
        eer_op  = op_w;
        busy    = (state != ST_IDLE);
        status  = res_q;
    end

    // R7: request fields hold until acknowledged.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        eer_req && !eer_ack |=> eer_req && $stable(eer_op) && $stable(eer_addr) && $stable(eer_wdata));
    // R7: request drops after an acknowledge.
    a_r7_drop: assert property (@(posedge clk) disable iff (!rst_n)
        eer_req && eer_ack |=> !eer_req);
    // R8: done is a single-cycle pulse and busy is already low with it.
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_busy_low: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R3: no erase or write before the old address is complete.
    a_r3_read_first: assert property (@(posedge clk) disable iff (!rst_n)
        eer_req && (eer_op == OP_ERASE || eer_op == OP_WRITE) |-> old_mac_valid);
    // R2: a bad header ends the run before the address is read.
    a_r2_abort: assert property (@(posedge clk) disable iff (!rst_n)
        done && status == RES_BAD_HDR |-> !old_mac_valid);
    // R9: a start while busy leaves the run going.
    a_r9_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start && !eer_ack |=> busy);
endmodule

// File: tb/sim_mac_prov_seq.sv
module sim_mac_prov_seq;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        start = 0;
    logic        update_en = 0;
    logic [47:0] new_mac = '0;
    logic        eer_req;
    logic [2:0]  eer_op;
    logic [5:0]  eer_addr;
    logic [15:0] eer_wdata;
    logic        eer_ack = 0;
    logic [15:0] eer_rdata = '0;
    logic        eer_err = 0;
    logic [47:0] old_mac;
    logic        old_mac_valid, busy, done;
    logic [1:0]  status;

    always #4 clk = ~clk;   // 125 MHz

    mac_prov_seq u0 (.*);

    int n_tests = 0, n_fail = 0;
    logic [15:0] mem [0:63];
    logic        wen = 0;
    int          inj_addr = -1;
    int          lat = 0;
    logic [2:0]  log_op [0:31];
    logic [5:0]  log_addr [0:31];
    logic [15:0] log_dat [0:31];
    int          log_n = 0;
    int          cyc = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Model EEPROM master: random latency, one-cycle ack, logs requests.
    initial begin
        forever begin
            @(negedge clk);
            if (eer_ack) begin
                eer_ack = 0; eer_err = 0;
            end else if (eer_req) begin
                if (lat > 0) lat--;
                else begin
                    if (log_n < 32) begin
                        log_op[log_n] = eer_op; log_addr[log_n] = eer_addr;
                        log_dat[log_n] = eer_wdata;
                    end
                    log_n++;
                    eer_err = 0;
                    case (eer_op)
                        3'd0: eer_rdata = mem[eer_addr];
                        3'd1: if (wen && int'(eer_addr) != inj_addr) mem[eer_addr] = eer_wdata;
                              else eer_err = 1;
                        3'd2: if (wen) mem[eer_addr] = 16'hFFFF; else eer_err = 1;
                        3'd3: wen = 1;
                        3'd4: wen = 0;
                        default: eer_err = 1;
                    endcase
                    eer_ack = 1;
                    lat = int'($urandom % 4);
                end
            end
        end
    end

    function automatic logic [15:0] pack_w(logic [47:0] m, int k);
        return {m[47-8*(2*k+1) -: 8], m[47-8*(2*k) -: 8]};
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One run: corrupt = header word to spoil (-1 none), inj = word whose write fails.
    task automatic run(bit upd, logic [47:0] nm, int corrupt, int inj, bit poke);
        logic [2:0]  e_op [0:15];
        logic [5:0]  e_addr [0:15];
        logic [15:0] e_dat [0:15];
        int e_n = 0, wait_c = 0;
        logic [47:0] e_old;
        logic [1:0]  e_st;
        bit seq_ok;
        for (int i = 0; i < 64; i++) mem[i] = 16'($urandom);
        mem[0] = 16'h8129; mem[1] = 16'h10EC; mem[2] = 16'h8168;
        if (corrupt >= 0) mem[corrupt] = mem[corrupt] ^ (16'h1 << ($urandom % 16));
        for (int k = 0; k < 3; k++) e_old[47-16*k -: 16] = {mem[7+k][7:0], mem[7+k][15:8]};
        inj_addr = inj; wen = 0; log_n = 0;
        for (int i = 0; i < 3; i++) begin
            if (corrupt < 0 || i <= corrupt) begin
                e_op[e_n] = 0; e_addr[e_n] = 6'(i); e_dat[e_n] = 0; e_n++;
            end
        end
        if (corrupt >= 0) e_st = 2'd1;
        else begin
            for (int k = 0; k < 3; k++) begin e_op[e_n] = 0; e_addr[e_n] = 6'(7+k); e_dat[e_n] = 0; e_n++; end
            e_st = 2'd0;
            if (upd) begin
                e_op[e_n] = 3; e_addr[e_n] = 0; e_dat[e_n] = 0; e_n++;
                for (int k = 0; k < 3; k++) begin
                    e_op[e_n] = 2; e_addr[e_n] = 6'(7+k); e_dat[e_n] = 0; e_n++;
                    e_op[e_n] = 1; e_addr[e_n] = 6'(7+k); e_dat[e_n] = pack_w(nm, k); e_n++;
                end
                e_op[e_n] = 4; e_addr[e_n] = 0; e_dat[e_n] = 0; e_n++;
                if (inj >= 7 && inj <= 9) e_st = 2'd2;
            end
        end
        @(negedge clk); start = 1; update_en = upd; new_mac = nm;
        @(negedge clk); start = 0;
        chk(busy == 1, "R8", "busy after start", 64'(busy), 1);
        if (poke) begin
            repeat (6) @(negedge clk);
            start = 1; update_en = ~upd; new_mac = ~nm;   // R9: must be ignored
            @(negedge clk); start = 0;
        end
        while (!done && wait_c < 3000) begin @(negedge clk); wait_c++; end
        if (!done) begin
            chk(0, "R8", "done timeout", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
        chk(status == e_st, corrupt >= 0 ? "R2" : (inj >= 0 && upd ? "R6" : "R4"),
            "status", 64'(status), 64'(e_st));
        chk(busy == 0, "R8", "busy with done", 64'(busy), 0);
        chk(log_n == e_n, poke ? "R9" : (upd ? "R5" : "R4"), "request count", 64'(log_n), 64'(e_n));
        seq_ok = 1;
        for (int i = 0; i < e_n && i < log_n; i++)
            if (log_op[i] != e_op[i] || log_addr[i] != e_addr[i] ||
                (e_op[i] == 1 && log_dat[i] != e_dat[i])) seq_ok = 0;
        chk(seq_ok, corrupt >= 0 ? "R2" : "R5", "request order", 64'(seq_ok), 1);
        if (corrupt < 0) begin
            chk(old_mac == e_old && old_mac_valid, "R3", "old mac", 64'(old_mac), 64'(e_old));
            if (upd) begin
                chk(wen == 0, "R6", "left write-enabled", 64'(wen), 0);
                for (int k = 0; k < 3; k++) begin
                    logic [15:0] ew;
                    ew = (inj == 7+k) ? 16'hFFFF : pack_w(nm, k);
                    chk(mem[7+k] == ew, poke ? "R9" : "R5", "stored word", 64'(mem[7+k]), 64'(ew));
                end
            end
        end else begin
            chk(old_mac_valid == 0, "R2", "valid after bad header", 64'(old_mac_valid), 0);
        end
        @(negedge clk);
        chk(done == 0, "R8", "done pulse width", 64'(done), 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(eer_req == 0 && done == 0 && busy == 0 && old_mac_valid == 0 && status == 0,
            "R1", "in reset", {eer_req, done, busy, old_mac_valid, status}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(eer_req == 0 && done == 0 && busy == 0 && old_mac_valid == 0 && status == 0,
            "R1", "after reset", {eer_req, done, busy, old_mac_valid, status}, 0);
        // Directed corners
        run(1, 48'h0011_2233_4455, -1, -1, 0);     // R5 plain update
        run(0, 48'hA1B2_C3D4_E5F6, -1, -1, 0);     // R4 read only
        for (int c = 0; c < 3; c++) run(1, 48'hDEAD_BEEF_0001, c, -1, 0);  // R2 each header word
        for (int w = 7; w <= 9; w++) run(1, 48'h0102_0304_0506, -1, w, 0); // R6 each word fails
        run(1, 48'hCAFE_F00D_1234, -1, -1, 1);     // R9 start while busy
        run(0, 48'h5555_AAAA_5555, -1, -1, 1);     // R9 read-only poked
        // Random mix
        for (int t = 0; t < 20; t++) begin
            int c, w;
            c = ($urandom % 4 == 0) ? int'($urandom % 3) : -1;
            w = ($urandom % 3 == 0) ? 7 + int'($urandom % 3) : -1;
            run(1'($urandom), {$urandom, 16'($urandom)}, c, w, 1'($urandom % 5 == 0));
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule